// File: doc/BRIEF.md
# Supervisor Counter Overflow Status Word

This block keeps one sticky overflow flag for each programmable performance counter, numbered 3 to 31. A flag is set when its counter wraps from all ones to zero. It stays set until a machine-level clear strobe for that counter arrives. The flags are gathered into one 32-bit read-only status word at CSR address 0xDA0. Supervisor-level overflow handlers can read this word to find out which counters overflowed, without calling up into machine mode.

Visibility depends on the privilege mode. Machine mode sees every flag. S/HS mode sees a flag only when the machine counter-enable word allows that counter. VS mode sees a flag only when the machine and hypervisor counter-enable words both allow it. A hidden bit reads as zero and does not trap. A write aimed at the word changes nothing and raises a one-cycle illegal-access pulse.

The CSR read path is purely combinational from the flags, the enable words and the mode. Only the flags and the illegal-access pulse are registered.

Top module: `ovf_status_csr`

## Requirements
- R1: `csr_hit` is high exactly when `csr_req` is high and `csr_addr` equals 0xDA0. `csr_rdata` is zero whenever `csr_hit` is low or `csr_we` is high.
- R2: Bits 2..0 of `csr_rdata` always read zero, and `ovf_wrap` or `ovf_clr` on bits 2..0 has no effect.
- R3: With `priv_mode` = 2'b11 (machine), a read returns every flag of counters 3..31 unmasked.
- R4: With `priv_mode` = 2'b01 (S/HS), bit X of a read is flag X AND `m_cnt_en[X]`.
- R5: With `priv_mode` = 2'b10 (VS), bit X of a read is flag X AND `m_cnt_en[X]` AND `h_cnt_en[X]`.
- R6: With `priv_mode` = 2'b00 (user), a read returns zero.
- R7: `ovf_wrap[X]` high at a clock edge sets flag X. The flag is visible to a read in the next cycle and stays set with no further wrap.
- R8: `ovf_clr[X]` high at an edge clears flag X, unless `ovf_wrap[X]` is high at the same edge, in which case the flag stays set.
- R9: Reset (`rst_n` low) clears every flag.
- R10: A write request to 0xDA0 leaves every flag unchanged, and `illegal_wr` is high for exactly the cycle after it. `illegal_wr` is low at all other times.
- R11: A change of `priv_mode`, `m_cnt_en` or `h_cnt_en` shows on `csr_rdata` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_wrap | input | 32 | Per-counter wrap event, one bit per counter index |
| ovf_clr | input | 32 | Per-counter machine-level clear strobe |
| m_cnt_en | input | 32 | Machine counter-enable word |
| h_cnt_en | input | 32 | Hypervisor counter-enable word |
| priv_mode | input | 2 | Current mode: 11 M, 01 S/HS, 10 VS, 00 U |
| csr_req | input | 1 | CSR access request |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_rdata | output | 32 | Masked status word |
| csr_hit | output | 1 | Request addresses the status word |
| illegal_wr | output | 1 | One-cycle pulse after a write to the status word |

## Verification
The bench aims at a wrap and a clear landing on the same counter in the same cycle. A design that lets the clear win would lose an overflow that really happened. It switches modes and enable words while flags are held, so a mask taken from the wrong enable word, or applied one cycle late, shows up as exposed or missing bits. It also drives wraps and clears on counters 0..2, which a design without the fixed-counter exclusion would expose in the low bits. Finally it writes to the address, which catches a design that corrupts flags, returns data during a write, or stretches the illegal-access pulse.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    localparam int WORD_W     = 32;
    localparam int FIRST_PROG = 3;
    localparam int ADDR_W     = 12;

    typedef enum logic [1:0] {
        PRV_U  = 2'b00,
        PRV_S  = 2'b01,
        PRV_VS = 2'b10,
        PRV_M  = 2'b11
    } priv_e;

    // Bits that belong to programmable counters.
    function automatic logic [WORD_W-1:0] prog_bits(input int first);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i >= first);
        end
        return m;
    endfunction

endpackage

// File: rtl/ovf_flag_bank.sv
module ovf_flag_bank
    import ovf_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int FIRST = FIRST_PROG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wrap_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    localparam logic [W-1:0] PROG = prog_bits(FIRST);

    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t state_d, state_q;
    logic [W-1:0] flag_nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < FIRST) begin : g_fixed
            // Fixed counters own no flag; their strobes are discarded.
            assign flag_nxt[i] = (wrap_i[i] | clr_i[i]) & 1'b0;
        end else begin : g_prog
            // Wrap dominates a simultaneous clear.
            assign flag_nxt[i] = wrap_i[i] | (state_q.flags[i] & ~clr_i[i]);
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.flags = flag_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.flags;

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        |(wrap_i & PROG) |=> ((flags_o & $past(wrap_i & PROG)) == $past(wrap_i & PROG))) // R7
        else $error("wrap did not set flag");

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & ~wrap_i) |=> ((flags_o & $past(clr_i & ~wrap_i)) == '0)) // R8
        else $error("clear did not drop flag");

    AST_FIXED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~PROG) == '0) // R2
        else $error("fixed counter holds a flag");

endmodule

// File: rtl/ovf_view_mask.sv
module ovf_view_mask
    import ovf_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int FIRST = FIRST_PROG
) (
    input  logic [1:0]   priv_i,
    input  logic [W-1:0] m_en_i,
    input  logic [W-1:0] h_en_i,
    output logic [W-1:0] mask_o
);

    localparam logic [W-1:0] PROG = prog_bits(FIRST);

    always_comb begin
        unique case (priv_e'(priv_i))
            PRV_M:   mask_o = PROG;
            PRV_S:   mask_o = PROG & m_en_i;
            PRV_VS:  mask_o = PROG & m_en_i & h_en_i;
            default: mask_o = '0;
        endcase
    end

    always_comb begin
        AST_MASK_LOW_ZERO: assert (mask_o[FIRST-1:0] == '0) // R2
            else $error("low mask bits open");
    end

endmodule

// File: rtl/ovf_csr_port.sv
module ovf_csr_port
    import ovf_pkg::*;
#(
    parameter int              W     = WORD_W,
    parameter int              AW    = ADDR_W,
    parameter logic [AW-1:0]   ADDR  = 12'hDA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  flags_i,
    input  logic [W-1:0]  mask_i,
    output logic [W-1:0]  rdata_o,
    output logic          hit_o,
    output logic          illegal_o
);

    typedef struct packed {
        logic illegal;
    } port_t;

    port_t st_d, st_q;
    logic  wr_hit;

    assign hit_o  = req_i && (addr_i == ADDR);
    assign wr_hit = hit_o && we_i;

    always_comb begin
        rdata_o = (hit_o && !we_i) ? (flags_i & mask_i) : '0;
    end

    always_comb begin
        st_d         = st_q;
        st_d.illegal = wr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign illegal_o = st_q.illegal;

    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> illegal_o) // R10
        else $error("missing illegal pulse");

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(req_i && we_i && addr_i == ADDR)) // R10
        else $error("spurious illegal pulse");

    AST_QUIET_OFF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_o || we_i) |-> (rdata_o == '0)) // R1
        else $error("data outside a read hit");

    AST_NO_HIDDEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~mask_i) == '0) // R4
        else $error("masked bit exposed");

endmodule

// File: rtl/ovf_status_csr.sv
module ovf_status_csr
    import ovf_pkg::*;
#(
    parameter int            W     = WORD_W,
    parameter int            FIRST = FIRST_PROG,
    parameter int            AW    = ADDR_W,
    parameter logic [AW-1:0] ADDR  = 12'hDA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  ovf_wrap,
    input  logic [W-1:0]  ovf_clr,
    input  logic [W-1:0]  m_cnt_en,
    input  logic [W-1:0]  h_cnt_en,
    input  logic [1:0]    priv_mode,
    input  logic          csr_req,
    input  logic          csr_we,
    input  logic [AW-1:0] csr_addr,
    output logic [W-1:0]  csr_rdata,
    output logic          csr_hit,
    output logic          illegal_wr
);

    logic [W-1:0] flags;
    logic [W-1:0] mask;

    ovf_flag_bank #(.W(W), .FIRST(FIRST)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (ovf_wrap),
        .clr_i   (ovf_clr),
        .flags_o (flags)
    );

    ovf_view_mask #(.W(W), .FIRST(FIRST)) u_mask (
        .priv_i (priv_mode),
        .m_en_i (m_cnt_en),
        .h_en_i (h_cnt_en),
        .mask_o (mask)
    );

    ovf_csr_port #(.W(W), .AW(AW), .ADDR(ADDR)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (csr_req),
        .we_i      (csr_we),
        .addr_i    (csr_addr),
        .flags_i   (flags),
        .mask_i    (mask),
        .rdata_o   (csr_rdata),
        .hit_o     (csr_hit),
        .illegal_o (illegal_wr)
    );

    AST_M_SEES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && !csr_we && priv_mode == 2'b11) |-> (csr_rdata == flags)) // R3
        else $error("machine read masked");

    AST_VS_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode == 2'b10) |-> ((csr_rdata & ~(m_cnt_en & h_cnt_en)) == '0)) // R5
        else $error("VS read leaks");

    AST_USER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode == 2'b00) |-> (csr_rdata == '0)) // R6
        else $error("user read nonzero");

    AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && csr_we && ovf_wrap == '0 && ovf_clr == '0) |=> $stable(flags)) // R10
        else $error("write altered flags");

endmodule

// File: tb/tb_ovf_status_csr.sv
module tb_ovf_status_csr;

    localparam logic [11:0] A = 12'hDA0;
    localparam logic [31:0] PROG = 32'hFFFF_FFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wrap = '0, clr = '0, men = '0, hen = '0;
    logic [1:0]  priv = 2'b11;
    logic        req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] rdata;
    logic        hit, ill;

    int total = 0, bad = 0;
    bit done = 0;

    logic [31:0] m_flags = '0;
    logic        m_ill = 1'b0;

    always #5 clk = ~clk;

    ovf_status_csr dut (
        .clk(clk), .rst_n(rst_n), .ovf_wrap(wrap), .ovf_clr(clr),
        .m_cnt_en(men), .h_cnt_en(hen), .priv_mode(priv),
        .csr_req(req), .csr_we(we), .csr_addr(addr),
        .csr_rdata(rdata), .csr_hit(hit), .illegal_wr(ill)
    );

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0;
            m_ill   = 1'b0;
        end else begin
            for (int i = 3; i < 32; i++) begin
                if (wrap[i]) m_flags[i] = 1'b1;
                else if (clr[i]) m_flags[i] = 1'b0;
            end
            m_ill = req && we && (addr == A);
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] mk;
        case (priv)
            2'b11:   mk = PROG;
            2'b01:   mk = PROG & men;
            2'b10:   mk = PROG & men & hen;
            default: mk = '0;
        endcase
        if (!(req && addr == A) || we) return '0;
        return m_flags & mk;
    endfunction

    function automatic string tag_of();
        if (!(req && addr == A)) return "R1";
        if (we) return "R10";
        case (priv)
            2'b11: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model, 2 ns after the inputs settle.
    task automatic compare();
        #2;
        check(tag_of(), rdata, exp_rdata());
        check("R1", {31'b0, hit}, {31'b0, req && addr == A});
        check("R10", {31'b0, ill}, {31'b0, m_ill});
        check("R2", {29'b0, rdata[2:0]}, 32'b0);
    endtask

    task automatic step(input logic [31:0] w, input logic [31:0] c, input logic [1:0] p,
                        input logic [31:0] me, input logic [31:0] he,
                        input logic r, input logic wr, input logic [11:0] ad);
        @(negedge clk);
        wrap = w; clr = c; priv = p; men = me; hen = he;
        req = r; we = wr; addr = ad;
        compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state, machine view of the whole word.
        req = 1'b1; addr = A; priv = 2'b11;
        #1 check("R9", rdata, 32'h0);
        check("R9", {31'b0, ill}, 32'h0);
        rst_n = 1'b1;

        // R2: wraps on fixed counters leave nothing behind.
        step(32'h0000_0007, '0, 2'b11, '0, '0, 1, 0, A);
        step('0, '0, 2'b11, '0, '0, 1, 0, A);
        // R7: set a few flags, sticky afterwards.
        step(32'h8000_0108, '0, 2'b11, '0, '0, 1, 0, A);
        step('0, '0, 2'b11, '0, '0, 1, 0, A);
        check("R7", rdata, 32'h8000_0108);
        step('0, '0, 2'b11, '0, '0, 1, 0, A);
        // R4 / R5 / R6 / R11: same flags under changing views.
        step('0, '0, 2'b01, 32'h0000_0108, '0, 1, 0, A);
        check("R4", rdata, 32'h0000_0108);
        step('0, '0, 2'b10, 32'h0000_0108, 32'h8000_0100, 1, 0, A);
        check("R5", rdata, 32'h0000_0100);
        step('0, '0, 2'b10, 32'hFFFF_FFFF, 32'h8000_0100, 1, 0, A);
        check("R11", rdata, 32'h8000_0100);
        step('0, '0, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, A);
        check("R6", rdata, 32'h0);
        // R1: wrong address.
        step('0, '0, 2'b11, '0, '0, 1, 0, 12'hDA1);
        check("R1", rdata, 32'h0);
        // R8: clear and simultaneous wrap+clear.
        step(32'h0000_0100, 32'h8000_0108, 2'b11, '0, '0, 1, 0, A);
        step('0, '0, 2'b11, '0, '0, 1, 0, A);
        check("R8", rdata, 32'h0000_0100);
        // R10: write attempt, then pulse, then quiet.
        step('0, '0, 2'b11, '0, '0, 1, 1, A);
        check("R10", rdata, 32'h0);
        step('0, '0, 2'b11, '0, '0, 1, 0, A);
        check("R10", {31'b0, ill}, 32'h1);
        check("R10", rdata, 32'h0000_0100);
        step('0, '0, 2'b11, '0, '0, 1, 0, A);
        check("R10", {31'b0, ill}, 32'h0);
        // R2: clear strobes on fixed counters.
        step('0, 32'h0000_0007, 2'b11, '0, '0, 1, 0, A);

        // Mixed traffic against the model.
        for (int n = 0; n < 400; n++) begin
            step($urandom & $urandom & $urandom, $urandom & $urandom,
                 2'($urandom), $urandom, $urandom,
                 ($urandom % 4) != 0, ($urandom % 8) == 0,
                 (($urandom % 6) == 0) ? 12'hDA4 : A);
        end

        // R9: reset in the middle of use.
        @(negedge clk);
        wrap = '0; clr = '0; we = 1'b0; req = 1'b1; addr = A; priv = 2'b11;
        rst_n = 1'b0;
        #1 check("R9", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        compare();
        finish_run();
    end

endmodule